// File: doc/BRIEF.md
# Cut-Through ICMP Echo Turnaround

This block sits between the receive byte stream and the transmit byte stream of an Ethernet MAC and answers ping requests without buffering whole frames. Each byte is presented with a valid strobe and start-of-frame and end-of-frame markers. The block passes every frame through a twelve-byte delay line and edits it on the way. The two MAC addresses are exchanged, and so are the two IPv4 addresses. The ICMP type byte is cleared, which turns a request into a reply, and the ICMP checksum is corrected incrementally. The IPv4 header checksum is left as it is, because exchanging the two addresses does not change its sum. The reply starts leaving seven cycles after the request starts arriving.

The frame is classified while it flows. A frame that is not a plain IPv4 ICMP echo request, is too short, or carries a receive error on any byte is still sent out, but its final output byte comes with an abort flag so that the MAC discards it. The MAC appends the frame CRC. Frame bytes must arrive on consecutive cycles from start to end; idle cycles are allowed only between frames, and frames may also follow one another with no gap.

Byte offsets below count from 0 at the first destination-MAC byte.

Top module: `icmp_echo_turnaround`

## Requirements
- R1: While reset is active and until the first frame has travelled the delay, out_valid, out_sof, out_eof and out_abort are all 0.
- R2: out_valid, out_sof and out_eof repeat in_valid, in_sof and in_eof of seven clock cycles earlier, for every cycle.
- R3: Output bytes 0..5 are input bytes 6..11, and output bytes 6..11 are input bytes 0..5, so the two MAC addresses are exchanged.
- R4: Output bytes 26..29 are input bytes 30..33, and output bytes 30..33 are input bytes 26..29, so the two IPv4 addresses are exchanged.
- R5: Output byte 34 (the ICMP type) is always 0x00.
- R6: Output bytes 36 (high) and 37 (low) hold the input 16-bit value at those offsets plus 0x0800 in one's-complement arithmetic, with the carry out of bit 15 added back at bit 0.
- R7: Every other byte, including the IPv4 header checksum at bytes 24..25 and all bytes from 38 on, leaves unchanged.
- R8: out_abort is 1 on the last byte of a frame whose bytes 12..13 are not 0x08 0x00, whose byte 14 is not 0x45, whose byte 23 is not 0x01, or whose byte 34 is not 0x08.
- R9: out_abort is 1 on the last byte of a frame in which in_err was 1 with any of its bytes, including the last one.
- R10: out_abort is 1 on the last byte of any frame shorter than 38 bytes, including a one-byte frame that has start and end on the same byte.
- R11: out_abort is 1 only together with out_eof and out_valid, and it stays 0 for a well-formed echo request of 38 bytes or more.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_data | input | 8 | Received frame byte |
| in_valid | input | 1 | in_data holds a frame byte |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| in_err | input | 1 | Receive error on this byte |
| out_data | output | 8 | Transmitted frame byte |
| out_valid | output | 1 | out_data holds a frame byte |
| out_sof | output | 1 | First byte of the outgoing frame |
| out_eof | output | 1 | Last byte of the outgoing frame |
| out_abort | output | 1 | Discard the outgoing frame; set only on its last byte |

## Verification
Two collisions matter. The abort decision can fall on the same byte as the frame's last edit, and the first six bytes of a new frame are fetched from the input while the tail of the previous frame still drains from the delay line. The bench provokes the first with frames of exactly 37 and 38 bytes and with a receive error on the final byte. It provokes the second by sending frames back to back with no idle cycle, including one right after a one-byte frame. A behavioural model predicts every output cycle from the byte offsets in the requirements, and any disagreement in flags, data or abort on either side of a frame boundary counts as a miscompare.

// File: rtl/echo_pkg.sv
package echo_pkg;

  // one cycle of the byte stream as it travels through the delay line
  typedef struct packed {
    logic [7:0] data;
    logic       valid;
    logic       sof;
    logic       eof;
    logic       err;
  } slot_t;

  // frame layout (byte offsets from the first destination-MAC byte)
  localparam int MAC_ADDR_B  = 6;
  localparam int IP_ADDR_B   = 4;
  localparam int OFS_ETYPE   = 12;
  localparam int OFS_VIHL    = 14;
  localparam int OFS_PROTO   = 23;
  localparam int OFS_IPSRC   = 26;
  localparam int OFS_ITYPE   = 34;
  localparam int OFS_ICK     = 36;
  localparam int MIN_FRAME   = 38;

  localparam logic [7:0]  ETYPE_HI   = 8'h08;
  localparam logic [7:0]  ETYPE_LO   = 8'h00;
  localparam logic [7:0]  VIHL_PLAIN = 8'h45;
  localparam logic [7:0]  PROTO_ICMP = 8'h01;
  localparam logic [7:0]  ICMP_REQ   = 8'h08;
  localparam logic [7:0]  ICMP_REP   = 8'h00;
  localparam logic [15:0] ICMP_ADJ   = 16'h0800;

  // 16-bit one's-complement addition with end-around carry
  function automatic logic [15:0] ones_add(input logic [15:0] a, input logic [15:0] b);
    logic [16:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[15:0] + {15'd0, s[16]};
  endfunction

endpackage

// File: rtl/echo_tap_line.sv
module echo_tap_line
  import echo_pkg::*;
#(
  parameter int DEPTH = 12
) (
  input  logic  clk,
  input  logic  rst_n,
  input  slot_t din,
  output slot_t tap [DEPTH]
);

  slot_t sr [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) sr[k] <= '0;
    end else begin
      sr[0] <= din;
      for (int k = 1; k < DEPTH; k++) sr[k] <= sr[k-1];
    end
  end

  assign tap = sr;

endmodule

// File: rtl/echo_frame_class.sv
module echo_frame_class
  import echo_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  slot_t            ctr,
  output logic [CNT_W-1:0] idx,
  output logic             abort_now
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             bad_q;
  logic             field_bad;   // this byte alone disqualifies the frame

  assign idx = ctr.sof ? '0 : cnt_q;

  always_comb begin
    field_bad = 1'b0;
    case (int'(idx))
      OFS_ETYPE:     field_bad = (ctr.data != ETYPE_HI);
      OFS_ETYPE + 1: field_bad = (ctr.data != ETYPE_LO);
      OFS_VIHL:      field_bad = (ctr.data != VIHL_PLAIN);
      OFS_PROTO:     field_bad = (ctr.data != PROTO_ICMP);
      OFS_ITYPE:     field_bad = (ctr.data != ICMP_REQ);
      default:       field_bad = 1'b0;
    endcase
    if (ctr.err) field_bad = 1'b1;
    if (ctr.eof && (int'(idx) < MIN_FRAME - 1)) field_bad = 1'b1;
    if (!ctr.valid) field_bad = 1'b0;
  end

  assign abort_now = ctr.valid && ctr.eof && (field_bad || (!ctr.sof && bad_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      bad_q <= 1'b0;
    end else if (ctr.valid) begin
      cnt_q <= (idx == CNT_MAX) ? CNT_MAX : idx + CNT_W'(1);
      bad_q <= ctr.sof ? field_bad : (bad_q | field_bad);
    end
  end

  // R9: a receive error on a closing byte always kills that frame
  a_r9_err_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    (ctr.valid && ctr.eof && ctr.err) |-> abort_now);

endmodule

// File: rtl/echo_rewrite.sv
module echo_rewrite
  import echo_pkg::*;
#(
  parameter int CNT_W = 6,
  parameter int MACB  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       fwd_d,
  input  logic [7:0]       back_d,
  input  logic [7:0]       ipf_d,
  input  logic [7:0]       ipb_d,
  input  logic [7:0]       nxt_d,
  input  logic [7:0]       prv_d,
  input  logic [7:0]       ctr_d,
  input  logic             ctr_v,
  input  logic             ctr_s,
  input  logic             ctr_e,
  input  logic [CNT_W-1:0] idx,
  input  logic             abort_now,
  output logic [7:0]       out_data,
  output logic             out_valid,
  output logic             out_sof,
  output logic             out_eof,
  output logic             out_abort
);

  localparam int IP_LO = OFS_IPSRC;
  localparam int IP_MID = OFS_IPSRC + IP_ADDR_B;
  localparam int IP_HI = OFS_IPSRC + 2 * IP_ADDR_B;

  logic [15:0] ck_hi_sum;
  logic [15:0] ck_lo_sum;
  logic [7:0]  new_byte;
  int          i;

  assign ck_hi_sum = ones_add({ctr_d, nxt_d}, ICMP_ADJ);
  assign ck_lo_sum = ones_add({prv_d, ctr_d}, ICMP_ADJ);
  assign i = int'(idx);

  always_comb begin
    new_byte = ctr_d;
    if (i < MACB)                      new_byte = fwd_d;
    else if (i < 2 * MACB)             new_byte = back_d;
    else if (i >= IP_LO && i < IP_MID) new_byte = ipf_d;
    else if (i >= IP_MID && i < IP_HI) new_byte = ipb_d;
    else if (i == OFS_ITYPE)           new_byte = ICMP_REP;
    else if (i == OFS_ICK)             new_byte = ck_hi_sum[15:8];
    else if (i == OFS_ICK + 1)         new_byte = ck_lo_sum[7:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_data  <= '0;
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_eof   <= 1'b0;
      out_abort <= 1'b0;
    end else begin
      out_data  <= new_byte;
      out_valid <= ctr_v;
      out_sof   <= ctr_s;
      out_eof   <= ctr_e;
      out_abort <= abort_now;
    end
  end

  // R3: leading MAC bytes are fetched from the byte arriving at the input
  a_r3_mac_swap: assert property (@(posedge clk) disable iff (!rst_n)
    (ctr_v && (i < MACB)) |=> (out_data == $past(fwd_d)));

  // R4: source IP bytes come from the destination field further ahead
  a_r4_ip_swap: assert property (@(posedge clk) disable iff (!rst_n)
    (ctr_v && (i >= IP_LO) && (i < IP_MID)) |=> (out_data == $past(ipf_d)));

  // R5: the type byte always leaves as a reply
  a_r5_type_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ctr_v && (i == OFS_ITYPE)) |=> (out_data == ICMP_REP));

endmodule

// File: rtl/icmp_echo_turnaround.sv
module icmp_echo_turnaround
  import echo_pkg::*;
#(
  parameter int MAC_BYTES = 6,
  parameter int CNT_W     = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  input  logic       in_sof,
  input  logic       in_eof,
  input  logic       in_err,
  output logic [7:0] out_data,
  output logic       out_valid,
  output logic       out_sof,
  output logic       out_eof,
  output logic       out_abort
);

  localparam int DEPTH = 2 * MAC_BYTES;
  localparam int CTR   = MAC_BYTES - 1;

  slot_t            din;
  slot_t            tap [DEPTH];
  logic [CNT_W-1:0] idx;
  logic             abort_now;

  assign din = '{data: in_data, valid: in_valid, sof: in_sof, eof: in_eof, err: in_err};

  echo_tap_line #(.DEPTH(DEPTH)) u_line (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (din),
    .tap  (tap)
  );

  echo_frame_class #(.CNT_W(CNT_W)) u_class (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctr      (tap[CTR]),
    .idx      (idx),
    .abort_now(abort_now)
  );

  echo_rewrite #(.CNT_W(CNT_W), .MACB(MAC_BYTES)) u_rw (
    .clk      (clk),
    .rst_n    (rst_n),
    .fwd_d    (in_data),
    .back_d   (tap[DEPTH-1].data),
    .ipf_d    (tap[CTR-IP_ADDR_B].data),
    .ipb_d    (tap[CTR+IP_ADDR_B].data),
    .nxt_d    (tap[CTR-1].data),
    .prv_d    (tap[CTR+1].data),
    .ctr_d    (tap[CTR].data),
    .ctr_v    (tap[CTR].valid),
    .ctr_s    (tap[CTR].sof),
    .ctr_e    (tap[CTR].eof),
    .idx      (idx),
    .abort_now(abort_now),
    .out_data (out_data),
    .out_valid(out_valid),
    .out_sof  (out_sof),
    .out_eof  (out_eof),
    .out_abort(out_abort)
  );

  // R11: the discard flag only ever rides on a closing byte
  a_r11_abort_on_eof: assert property (@(posedge clk) disable iff (!rst_n)
    out_abort |-> (out_eof && out_valid));

  // R2: frame markers never appear on an empty output cycle
  a_r2_marks_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (out_sof || out_eof) |-> out_valid);

endmodule

// File: tb/icmp_echo_turnaround_tb.sv
module icmp_echo_turnaround_tb;

  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 7;
  localparam int NSLOT      = 8192;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0, in_err = 1'b0;
  logic [7:0] out_data;
  logic       out_valid, out_sof, out_eof, out_abort;

  always #(CLK_PERIOD / 2) clk = ~clk;

  icmp_echo_turnaround u_dut (
    .clk(clk), .rst_n(rst_n),
    .in_data(in_data), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .in_err(in_err),
    .out_data(out_data), .out_valid(out_valid), .out_sof(out_sof), .out_eof(out_eof),
    .out_abort(out_abort)
  );

  int vectors = 0;
  int misses  = 0;
  int slot    = 0;

  logic       ex_v [NSLOT];
  logic       ex_s [NSLOT];
  logic       ex_e [NSLOT];
  logic       ex_a [NSLOT];
  logic       ex_dc[NSLOT];
  logic [7:0] ex_d [NSLOT];
  string      ex_dtag[NSLOT];
  string      ex_atag[NSLOT];

  task automatic miss(input string tag, input string what, input int act, input int exp);
    misses++;
    $display("FAIL %s %s slot %0d: actual %0h expected %0h", tag, what, slot, act, exp);
  endtask

  // compare the outputs against the slot driven LAT cycles earlier
  task automatic compare();
    int k;
    logic v, s, e, a, dc;
    logic [7:0] d;
    string dt, at, ft;
    k = slot - LAT;
    if (k < 0) begin
      v = 0; s = 0; e = 0; a = 0; dc = 1; d = 0; dt = "R1"; at = "R1"; ft = "R1";
    end else begin
      v = ex_v[k]; s = ex_s[k]; e = ex_e[k]; a = ex_a[k]; dc = ex_dc[k]; d = ex_d[k];
      dt = ex_dtag[k]; at = ex_atag[k]; ft = "R2";
    end
    vectors++;
    if (out_valid !== v) miss(ft, "out_valid", int'(out_valid), int'(v));
    if (out_sof !== s)   miss(ft, "out_sof", int'(out_sof), int'(s));
    if (out_eof !== e)   miss(ft, "out_eof", int'(out_eof), int'(e));
    if (out_abort !== a) miss(at, "out_abort", int'(out_abort), int'(a));
    if (v && !dc && out_data !== d) miss(dt, "out_data", int'(out_data), int'(d));
  endtask

  task automatic tick(input logic v, input logic s, input logic e, input logic er,
                      input logic [7:0] din, input logic [7:0] xd, input logic xdc,
                      input logic xa, input string dtag, input string atag);
    @(negedge clk);
    compare();
    in_valid = v; in_sof = s; in_eof = e; in_err = er; in_data = din;
    if (slot < NSLOT) begin
      ex_v[slot] = v; ex_s[slot] = s; ex_e[slot] = e; ex_a[slot] = xa;
      ex_d[slot] = xd; ex_dc[slot] = xdc; ex_dtag[slot] = dtag; ex_atag[slot] = atag;
    end
    slot++;
  endtask

  task automatic idle(input int n);
    for (int j = 0; j < n; j++) tick(0, 0, 0, 0, 8'h00, 8'h00, 1, 0, "R7", "R2");
  endtask

  // kind: 0 echo request, 1 wrong ethertype, 2 wrong version/length,
  //       3 wrong protocol, 4 not a request
  task automatic send(input int len, input int kind, input logic [15:0] ck,
                      input int errpos, input int gap, input string tag);
    logic [7:0] f[$];
    logic       bad;
    int         sum;
    logic [7:0] xd;
    string      dt;
    f = {};
    for (int j = 0; j < len; j++) begin
      logic [7:0] b;
      b = 8'((j * 7 + 3) & 255);
      if (j < 6)                    b = 8'hA0 + 8'(j);
      else if (j < 12)              b = 8'h50 + 8'(j);
      else if (j == 12)             b = 8'h08;
      else if (j == 13)             b = (kind == 1) ? 8'h06 : 8'h00;
      else if (j == 14)             b = (kind == 2) ? 8'h46 : 8'h45;
      else if (j == 23)             b = (kind == 3) ? 8'h11 : 8'h01;
      else if (j >= 26 && j < 30)   b = 8'hC0 + 8'(j);
      else if (j >= 30 && j < 34)   b = 8'h0A + 8'(j);
      else if (j == 34)             b = (kind == 4) ? 8'h00 : 8'h08;
      else if (j == 35)             b = 8'h00;
      else if (j == 36)             b = ck[15:8];
      else if (j == 37)             b = ck[7:0];
      f.push_back(b);
    end
    if (len < 38) bad = 1;
    else bad = (f[12] != 8'h08) || (f[13] != 8'h00) || (f[14] != 8'h45) ||
               (f[23] != 8'h01) || (f[34] != 8'h08);
    if (errpos >= 0) bad = 1;
    sum = 0;
    if (len >= 38) begin
      sum = int'({f[36], f[37]}) + 'h800;
      if (sum > 'hFFFF) sum = sum - 'hFFFF;
    end
    for (int j = 0; j < len; j++) begin
      xd = 8'h00; dt = "R7";
      if (len >= 38) begin
        if (j < 6)                  begin xd = f[j + 6]; dt = "R3"; end
        else if (j < 12)            begin xd = f[j - 6]; dt = "R3"; end
        else if (j >= 26 && j < 30) begin xd = f[j + 4]; dt = "R4"; end
        else if (j >= 30 && j < 34) begin xd = f[j - 4]; dt = "R4"; end
        else if (j == 34)           begin xd = 8'h00;    dt = "R5"; end
        else if (j == 36)           begin xd = 8'(sum >> 8); dt = "R6"; end
        else if (j == 37)           begin xd = 8'(sum & 255); dt = "R6"; end
        else                        xd = f[j];
      end
      tick(1, j == 0, j == len - 1, j == errpos, f[j], xd, len < 38,
           (j == len - 1) && bad, dt, tag);
    end
    idle(gap);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    misses++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin : main
    for (int j = 0; j < NSLOT; j++) begin
      ex_v[j] = 0; ex_s[j] = 0; ex_e[j] = 0; ex_a[j] = 0; ex_dc[j] = 1; ex_d[j] = 0;
      ex_dtag[j] = "R7"; ex_atag[j] = "R2";
    end
    repeat (4) @(negedge clk);
    // R1: outputs idle during reset
    vectors++;
    if ({out_valid, out_sof, out_eof, out_abort} !== 4'b0000)
      miss("R1", "flags in reset", int'({out_valid, out_sof, out_eof, out_abort}), 0);
    rst_n = 1'b1;
    idle(3);

    send(60, 0, 16'h1234, -1, 3, "R11");   // plain echo request
    send(42, 0, 16'hF800, -1, 2, "R6");    // checksum carry wraps around
    send(38, 0, 16'hF7FF, -1, 0, "R11");   // minimum length, back to back
    send(64, 1, 16'h2222, -1, 0, "R8");    // wrong ethertype
    send(50, 2, 16'h3333, -1, 1, "R8");    // header with options
    send(50, 3, 16'h4444, -1, 0, "R8");    // not ICMP
    send(50, 4, 16'h5555, -1, 2, "R8");    // already a reply
    send(55, 0, 16'h6666, 20, 2, "R9");    // error mid frame
    send(45, 0, 16'h7777, 44, 0, "R9");    // error on the last byte
    send(20, 0, 16'h8888, -1, 2, "R10");   // short
    send(37, 0, 16'h9999, -1, 0, "R10");   // one byte short
    send(1,  0, 16'hAAAA, -1, 0, "R10");   // start and end together
    send(70, 0, 16'hFFFF, -1, 0, "R11");   // right after a one-byte frame
    send(40, 0, 16'h0000, -1, 12, "R11");
    idle(4);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule